// File: doc/BRIEF.md
# Debug Module Abstract Command Front End

This block is the register side of a debug module serving one hart. A debug transport sends it requests on a port with a 7-bit address and 32-bit data. Each request is a read, a write or a no-op, and each one is answered exactly one cycle later. Behind that port the block holds:

- an activation bit and a halt request;
- a live status word built from the hart's running and halted inputs;
- an abstract-command register with a busy flag and a sticky error code;
- one data word;
- a two-entry program buffer.

A supported register-access command is passed to the hart as a one-cycle start pulse with its fields decoded. The block then waits for a done pulse and, for a read, stores the returned value in the data word. A command can also ask the hart to run the program buffer after the access, or instead of it. The hart's own execution of these requests lies outside the block.

Software first sets the activation bit. It then raises halt requests, issues commands and polls the busy flag. A command that is malformed is refused and recorded in the error code, and so is any access that arrives while a command is running. The error code stays set until software clears it by writing ones to it.

Top module: `dm_abs_front`

## Requirements
- R1: Every request with `dmiReqValid` high gets `dmiRspValid` high on the next cycle. Operation code 1 is a read and 2 is a write. A read returns the register value held before that request. Writes and no-ops return zero data.
- R2: While the activation bit (dmcontrol bit 0) is 0, every register read returns 0, `haltReq` is 0, and data0, the program buffer, busy and the error code are held cleared. A dmcontrol write with bit 0 set activates the block, but the halt-request bit of that same write is ignored. Once active, dmcontrol reads 0x00000001 even after all ones are written to the hart-select fields.
- R3: While the block is active, a dmcontrol write copies bit 31 to `haltReq`, and dmcontrol bit 31 reads back the same value. Software may clear it after the hart halts.
- R4: dmstatus (0x11) reads 0x00400C83 when `hartRunning`=1 and `hartHalted`=0. It reads 0x00400383 when `hartRunning`=0 and `hartHalted`=1. Bits 11:10 follow `hartRunning` and bits 9:8 follow `hartHalted`.
- R5: abstractcs (0x16) reads progbufsize 2 in bits 28:24, bit 11 as 1, datacount 1 in bits 3:0, busy in bit 12 and the error code in bits 10:8. When idle with no error it reads 0x02000801.
- R6: A command is rejected when any of the following holds: bits 31:23 are not zero; bit 19 is set; or transfer (bit 17) is set while the size field (bits 22:20) is not 2 or the register number (bits 15:0) is outside 0x1000..0x101F. A rejected command sets the error code to 2, does not set busy and gives no start pulse.
- R7: An accepted command with transfer set does three things: it pulses `cmdStart` for one cycle, with `cmdRegno`, `cmdWrite` (bit 16) and `cmdArg` = data0; it sets busy until `cmdDone`; and, for a read (bit 16 = 0), it loads `cmdResult` into data0.
- R8: An accepted command with postexec (bit 18) set and transfer clear starts with `cmdPostexec`=1 and `cmdTransfer`=0. A command with neither bit set completes at once, with no start pulse and no error.
- R9: Writing abstractcs clears each error-code bit written as 1 (for example 0x700 clears all of them).
- R10: A write to data0 (0x04), abstractcs or command (0x17) while busy sets the error code to 1 if it was 0. The write itself has no effect.
- R11: While the error code is nonzero, writes to command start nothing and leave the error code unchanged.
- R12: progbuf0 (0x20) and progbuf1 (0x21) are read/write and drive `progBuf` bits 31:0 and 63:32. sbcs (0x38) reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| dmiReqValid | input | 1 | Request present |
| dmiReqOp | input | 2 | 1 read, 2 write, 0 no-op |
| dmiReqAddr | input | 7 | Register address |
| dmiReqData | input | 32 | Write data |
| dmiRspValid | output | 1 | Response present, one cycle after a request |
| dmiRspData | output | 32 | Read data |
| haltReq | output | 1 | Halt request to the hart |
| hartHalted | input | 1 | Hart is halted |
| hartRunning | input | 1 | Hart is running |
| cmdStart | output | 1 | One-cycle start of an abstract command |
| cmdRegno | output | 16 | Register number of the command |
| cmdWrite | output | 1 | Command writes the register |
| cmdTransfer | output | 1 | Command performs a register transfer |
| cmdPostexec | output | 1 | Command runs the program buffer |
| cmdArg | output | 32 | Data word passed to the hart |
| cmdDone | input | 1 | Hart finished the command |
| cmdResult | input | 32 | Value returned by a register read |
| progBuf | output | 64 | Program buffer contents, entry 0 in the low word |

## Verification
The assertions take three things for granted. The hart raises `cmdDone` only while a command is outstanding. It pulses `cmdDone` for one cycle. The transport sends at most one request per cycle and never stacks requests while a response is pending. The bench's hart model answers each start pulse after a set latency with a single done pulse. Every request is issued through one task, which waits for its response before the next begins. Random commands mix legal and illegal sizes, register numbers and reserved bits. Each command is preceded by an error-code clear, so that the rejection rules and the busy rules are exercised separately.

// File: rtl/dm_front_pkg.sv
package dm_front_pkg;
  localparam int DM_AW   = 7;
  localparam int DM_DW   = 32;
  localparam int DM_PB_N = 2;

  localparam logic [DM_AW-1:0] ADDR_DATA0 = 7'h04;
  localparam logic [DM_AW-1:0] ADDR_CTRL  = 7'h10;
  localparam logic [DM_AW-1:0] ADDR_STAT  = 7'h11;
  localparam logic [DM_AW-1:0] ADDR_ACS   = 7'h16;
  localparam logic [DM_AW-1:0] ADDR_CMD   = 7'h17;
  localparam logic [DM_AW-1:0] ADDR_PB0   = 7'h20;
  localparam logic [DM_AW-1:0] ADDR_SBCS  = 7'h38;

  localparam logic [1:0] OP_READ  = 2'd1;
  localparam logic [1:0] OP_WRITE = 2'd2;

  localparam logic [2:0] ERR_NONE  = 3'd0;
  localparam logic [2:0] ERR_BUSY  = 3'd1;
  localparam logic [2:0] ERR_UNSUP = 3'd2;

  localparam logic [DM_DW-1:0] STAT_BASE = 32'h0040_0083;

  typedef struct packed {
    logic               wrCtl;
    logic               wrData0;
    logic               loadResult;
    logic [DM_PB_N-1:0] wrProg;
  } dmStrobe_t;
endpackage

// File: rtl/dm_front_ctrl.sv
module dm_front_ctrl
  import dm_front_pkg::*;
#(
  parameter int AW = DM_AW,
  parameter int DW = DM_DW
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic [1:0]    reqOp,
  input  logic [AW-1:0] reqAddr,
  input  logic [DW-1:0] reqData,
  input  logic          active,
  input  logic          cmdDone,
  output dmStrobe_t     stb,
  output logic          busy,
  output logic [2:0]    cmdErr,
  output logic          cmdStart,
  output logic [15:0]   cmdRegno,
  output logic          cmdWrite,
  output logic          cmdTransfer,
  output logic          cmdPostexec
);
  logic isWr, busyHit, cmdHit, acsHit, cmdOk, cmdRuns;

  assign isWr    = reqValid && (reqOp == OP_WRITE);
  assign busyHit = isWr && active && busy &&
                   (reqAddr == ADDR_DATA0 || reqAddr == ADDR_ACS || reqAddr == ADDR_CMD);
  assign cmdHit  = isWr && active && !busy && (cmdErr == ERR_NONE) && (reqAddr == ADDR_CMD);
  assign acsHit  = isWr && active && !busy && (reqAddr == ADDR_ACS);
  assign cmdOk   = (reqData[31:23] == 9'd0) && !reqData[19] &&
                   (!reqData[17] || (reqData[22:20] == 3'd2 && reqData[15:5] == 11'h080));
  assign cmdRuns = reqData[17] | reqData[18];

  always_comb begin
    stb.wrCtl      = isWr && (reqAddr == ADDR_CTRL);
    stb.wrData0    = isWr && active && !busy && (reqAddr == ADDR_DATA0);
    stb.loadResult = active && busy && cmdDone && cmdTransfer && !cmdWrite;
    for (int i = 0; i < DM_PB_N; i++)
      stb.wrProg[i] = isWr && active && (reqAddr == ADDR_PB0 + AW'(i));
  end

  always_ff @(posedge clk) begin
    if (!rstN || !active) begin
      busy        <= 1'b0;
      cmdErr      <= ERR_NONE;
      cmdStart    <= 1'b0;
      cmdRegno    <= '0;
      cmdWrite    <= 1'b0;
      cmdTransfer <= 1'b0;
      cmdPostexec <= 1'b0;
    end else begin
      cmdStart <= 1'b0;
      if (busy && cmdDone) busy <= 1'b0;
      if (busyHit) begin
        if (cmdErr == ERR_NONE) cmdErr <= ERR_BUSY;
      end else if (acsHit) begin
        cmdErr <= cmdErr & ~reqData[10:8];
      end else if (cmdHit) begin
        if (!cmdOk) begin
          cmdErr <= ERR_UNSUP;
        end else if (cmdRuns) begin
          busy        <= 1'b1;
          cmdStart    <= 1'b1;
          cmdRegno    <= reqData[15:0];
          cmdWrite    <= reqData[16];
          cmdTransfer <= reqData[17];
          cmdPostexec <= reqData[18];
        end
      end
    end
  end
endmodule

// File: rtl/dm_front_dp.sv
module dm_front_dp
  import dm_front_pkg::*;
#(
  parameter int AW = DM_AW,
  parameter int DW = DM_DW
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [1:0]            reqOp,
  input  logic [AW-1:0]         reqAddr,
  input  logic [DW-1:0]         reqData,
  input  dmStrobe_t             stb,
  input  logic                  busy,
  input  logic [2:0]            cmdErr,
  input  logic                  hartHalted,
  input  logic                  hartRunning,
  input  logic [DW-1:0]         cmdResult,
  output logic                  active,
  output logic                  haltReq,
  output logic [DW-1:0]         data0,
  output logic [DM_PB_N*DW-1:0] progBuf,
  output logic                  rspValid,
  output logic [DW-1:0]         rspData
);
  localparam int PBW = 5;

  logic [DW-1:0] pbMem [DM_PB_N];
  logic [DW-1:0] rdMux, statWord, acsWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      haltReq <= 1'b0;
    end else if (stb.wrCtl) begin
      active  <= reqData[0];
      haltReq <= active && reqData[0] && reqData[31];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !active)    data0 <= '0;
    else if (stb.wrData0)    data0 <= reqData;
    else if (stb.loadResult) data0 <= cmdResult;
  end

  for (genvar g = 0; g < DM_PB_N; g++) begin : gPb
    always_ff @(posedge clk) begin
      if (!rstN || !active)  pbMem[g] <= '0;
      else if (stb.wrProg[g]) pbMem[g] <= reqData;
    end
    assign progBuf[g*DW +: DW] = pbMem[g];
  end

  assign statWord = STAT_BASE | {20'd0, hartRunning, hartRunning, hartHalted, hartHalted, 8'd0};
  assign acsWord  = {3'd0, PBW'(DM_PB_N), 11'd0, busy, 1'b1, cmdErr, 4'd0, 4'd1};

  always_comb begin
    rdMux = '0;
    if (active) begin
      case (reqAddr)
        ADDR_CTRL:  rdMux = {haltReq, 30'd0, 1'b1};
        ADDR_STAT:  rdMux = statWord;
        ADDR_ACS:   rdMux = acsWord;
        ADDR_DATA0: rdMux = data0;
        ADDR_SBCS:  rdMux = '0;
        default:    rdMux = '0;
      endcase
      for (int i = 0; i < DM_PB_N; i++)
        if (reqAddr == ADDR_PB0 + AW'(i)) rdMux = pbMem[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= reqValid;
      rspData  <= (reqValid && reqOp == OP_READ) ? rdMux : '0;
    end
  end
endmodule

// File: rtl/dm_abs_front.sv
module dm_abs_front
  import dm_front_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          dmiReqValid,
  input  logic [1:0]    dmiReqOp,
  input  logic [6:0]    dmiReqAddr,
  input  logic [31:0]   dmiReqData,
  output logic          dmiRspValid,
  output logic [31:0]   dmiRspData,
  output logic          haltReq,
  input  logic          hartHalted,
  input  logic          hartRunning,
  output logic          cmdStart,
  output logic [15:0]   cmdRegno,
  output logic          cmdWrite,
  output logic          cmdTransfer,
  output logic          cmdPostexec,
  output logic [31:0]   cmdArg,
  input  logic          cmdDone,
  input  logic [31:0]   cmdResult,
  output logic [63:0]   progBuf
);
  dmStrobe_t  stb;
  logic       active;
  logic       busy;
  logic [2:0] cmdErr;

  dm_front_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(dmiReqValid), .reqOp(dmiReqOp),
    .reqAddr(dmiReqAddr), .reqData(dmiReqData), .active(active), .cmdDone(cmdDone),
    .stb(stb), .busy(busy), .cmdErr(cmdErr), .cmdStart(cmdStart), .cmdRegno(cmdRegno),
    .cmdWrite(cmdWrite), .cmdTransfer(cmdTransfer), .cmdPostexec(cmdPostexec)
  );

  dm_front_dp uDp (
    .clk(clk), .rstN(rstN), .reqValid(dmiReqValid), .reqOp(dmiReqOp),
    .reqAddr(dmiReqAddr), .reqData(dmiReqData), .stb(stb), .busy(busy), .cmdErr(cmdErr),
    .hartHalted(hartHalted), .hartRunning(hartRunning), .cmdResult(cmdResult),
    .active(active), .haltReq(haltReq), .data0(cmdArg), .progBuf(progBuf),
    .rspValid(dmiRspValid), .rspData(dmiRspData)
  );
endmodule

// File: rtl/dm_abs_front_chk.sv
module dm_abs_front_chk (
  input logic       clk,
  input logic       rstN,
  input logic       dmiReqValid,
  input logic [1:0] dmiReqOp,
  input logic [6:0] dmiReqAddr,
  input logic       dmiRspValid,
  input logic       haltReq,
  input logic       cmdStart,
  input logic       cmdDone,
  input logic       active,
  input logic       busy,
  input logic [2:0] cmdErr
);
  p_rsp_follows_r1: assert property (@(posedge clk) disable iff (!rstN)
    dmiReqValid |=> dmiRspValid);

  p_halt_needs_active_r2: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> !haltReq);

  p_start_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |=> !cmdStart);

  p_start_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |-> busy);

  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !cmdDone) |=> (busy || !active));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdErr != 3'd0 && !(dmiReqValid && dmiReqOp == 2'd2 && dmiReqAddr == 7'h16))
      |=> (cmdErr != 3'd0 || !active));

  p_no_start_on_err_r11: assert property (@(posedge clk) disable iff (!rstN)
    (cmdErr != 3'd0) |=> !cmdStart);
endmodule

bind dm_abs_front dm_abs_front_chk uChk (
  .clk(clk), .rstN(rstN), .dmiReqValid(dmiReqValid), .dmiReqOp(dmiReqOp),
  .dmiReqAddr(dmiReqAddr), .dmiRspValid(dmiRspValid), .haltReq(haltReq),
  .cmdStart(cmdStart), .cmdDone(cmdDone), .active(active), .busy(busy), .cmdErr(cmdErr)
);

// File: tb/tb_dm_abs_front.sv
module tb_dm_abs_front;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        dmiReqValid = 1'b0;
  logic [1:0]  dmiReqOp = 2'd0;
  logic [6:0]  dmiReqAddr = 7'd0;
  logic [31:0] dmiReqData = 32'd0;
  logic        dmiRspValid;
  logic [31:0] dmiRspData;
  logic        haltReq;
  logic        hartHalted = 1'b0;
  logic        hartRunning = 1'b1;
  logic        cmdStart;
  logic [15:0] cmdRegno;
  logic        cmdWrite, cmdTransfer, cmdPostexec;
  logic [31:0] cmdArg;
  logic        cmdDone = 1'b0;
  logic [31:0] cmdResult = 32'd0;
  logic [63:0] progBuf;

  always #(CLK_PERIOD/2) clk = ~clk;

  dm_abs_front dut (
    .clk(clk), .rstN(rstN), .dmiReqValid(dmiReqValid), .dmiReqOp(dmiReqOp),
    .dmiReqAddr(dmiReqAddr), .dmiReqData(dmiReqData), .dmiRspValid(dmiRspValid),
    .dmiRspData(dmiRspData), .haltReq(haltReq), .hartHalted(hartHalted),
    .hartRunning(hartRunning), .cmdStart(cmdStart), .cmdRegno(cmdRegno),
    .cmdWrite(cmdWrite), .cmdTransfer(cmdTransfer), .cmdPostexec(cmdPostexec),
    .cmdArg(cmdArg), .cmdDone(cmdDone), .cmdResult(cmdResult), .progBuf(progBuf)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  int          hartLat = 3;
  int          starts = 0;
  logic [15:0] lastRegno = '0;
  logic [31:0] lastArg = '0;
  logic        lastPost = 1'b0, lastXfer = 1'b0, lastWr = 1'b0;

  function automatic logic [31:0] resultFn(input logic [15:0] r);
    return {8'hD0, r[7:0] ^ 8'h3C, r};
  endfunction

  function automatic bit supportedFn(input logic [31:0] d);
    return (d[31:23] == 9'd0) && !d[19] &&
           (!d[17] || (d[22:20] == 3'd2 && d[15:5] == 11'h080));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] op, input logic [6:0] a, input logic [31:0] d,
                        output logic [31:0] r);
    @(negedge clk);
    dmiReqValid = 1'b1; dmiReqOp = op; dmiReqAddr = a; dmiReqData = d;
    @(negedge clk);
    dmiReqValid = 1'b0; dmiReqOp = 2'd0;
    if (dmiRspValid !== 1'b1) begin
      checks++; fails++;
      $display("FAIL R1 response valid actual=%b expected=1", dmiRspValid);
    end
    r = dmiRspData;
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    logic [31:0] r;
    access(2'd2, a, d, r);
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] r);
    access(2'd1, a, 32'd0, r);
  endtask

  task automatic waitIdle(output logic [31:0] acs);
    for (int k = 0; k < 60; k++) begin
      rd(7'h16, acs);
      if (!acs[12]) break;
    end
  endtask

  // Hart model: one done pulse per start, after hartLat cycles
  initial begin
    forever begin
      @(negedge clk);
      if (cmdStart === 1'b1) begin
        starts++;
        lastRegno = cmdRegno; lastArg = cmdArg;
        lastPost = cmdPostexec; lastXfer = cmdTransfer; lastWr = cmdWrite;
        repeat (hartLat) @(negedge clk);
        cmdResult = resultFn(lastRegno);
        cmdDone = 1'b1;
        @(negedge clk);
        cmdDone = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, acs, d, modelData0;
    int s0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R2 haltReq in reset", {31'd0, haltReq}, 32'd0);
    chk("R1 no response in reset", {31'd0, dmiRspValid}, 32'd0);
    rstN = 1'b1;

    // R2 inactive behaviour
    rd(7'h10, r);             chk("R2 dmcontrol inactive", r, 32'd0);
    wr(7'h04, 32'h1234_5678);
    rd(7'h11, r);             chk("R2 dmstatus inactive", r, 32'd0);
    wr(7'h10, 32'h8000_0001);
    rd(7'h10, r);             chk("R2 activation ignores haltreq", r, 32'h1);
    chk("R2 haltReq after activation", {31'd0, haltReq}, 32'd0);
    rd(7'h04, r);             chk("R2 data0 ignored while inactive", r, 32'd0);
    wr(7'h10, 32'h07FF_FFC1);
    rd(7'h10, r);             chk("R2 hart select reads zero", r, 32'h1);

    // R3 halt request
    wr(7'h10, 32'h8000_0001);
    rd(7'h10, r);             chk("R3 haltreq readback", r, 32'h8000_0001);
    chk("R3 haltReq pin", {31'd0, haltReq}, 32'd1);

    // R4 status
    rd(7'h11, r);             chk("R4 dmstatus running", r, 32'h0040_0C83);
    hartRunning = 1'b0; hartHalted = 1'b1;
    rd(7'h11, r);             chk("R4 dmstatus halted", r, 32'h0040_0383);
    wr(7'h10, 32'h1);
    chk("R3 haltReq cleared", {31'd0, haltReq}, 32'd0);

    // R5 / R12
    rd(7'h16, r);             chk("R5 abstractcs idle", r, 32'h0200_0801);
    rd(7'h38, r);             chk("R12 sbcs zero", r, 32'd0);
    wr(7'h20, 32'h3010_2473);
    wr(7'h21, 32'h0010_0073);
    rd(7'h20, r);             chk("R12 progbuf0", r, 32'h3010_2473);
    rd(7'h21, r);             chk("R12 progbuf1", r, 32'h0010_0073);
    chk("R12 progBuf pins low", progBuf[31:0], 32'h3010_2473);
    chk("R12 progBuf pins high", progBuf[63:32], 32'h0010_0073);

    // R6 unsupported size
    s0 = starts;
    wr(7'h17, 32'h0032_1008);
    rd(7'h16, r);             chk("R6 64-bit access rejected", r, 32'h0200_0A01);
    chk("R6 no start", starts, s0);
    // R11 commands blocked while error set
    wr(7'h17, 32'h0022_1005);
    repeat (2) @(negedge clk);
    chk("R11 no start with error", starts, s0);
    rd(7'h16, r);             chk("R11 error unchanged", r, 32'h0200_0A01);
    // R9 clear
    wr(7'h16, 32'h0000_0700);
    rd(7'h16, r);             chk("R9 error cleared", r, 32'h0200_0801);
    wr(7'h17, 32'h0022_0301);
    rd(7'h16, r);             chk("R6 bad regno rejected", r, 32'h0200_0A01);
    wr(7'h16, 32'h0000_0200);
    rd(7'h16, r);             chk("R9 partial clear", r, 32'h0200_0801);

    // R7 supported read
    s0 = starts;
    wr(7'h17, 32'h0022_1008);
    rd(7'h16, r);             chk("R7 busy while running", r, 32'h0200_1801);
    waitIdle(acs);            chk("R7 busy clears", acs, 32'h0200_0801);
    chk("R7 one start", starts, s0 + 1);
    chk("R7 regno", {16'd0, lastRegno}, 32'h1008);
    chk("R7 transfer", {31'd0, lastXfer}, 32'd1);
    rd(7'h04, r);             chk("R7 result in data0", r, resultFn(16'h1008));
    // R7 supported write
    wr(7'h04, 32'hCAFE_F00D);
    wr(7'h17, 32'h0023_1005);
    waitIdle(acs);
    chk("R7 write arg", lastArg, 32'hCAFE_F00D);
    chk("R7 write flag", {31'd0, lastWr}, 32'd1);
    rd(7'h04, r);             chk("R7 data0 kept on write", r, 32'hCAFE_F00D);

    // R8 postexec and no-op
    s0 = starts;
    wr(7'h17, 32'h0004_0000);
    waitIdle(acs);
    chk("R8 postexec started", starts, s0 + 1);
    chk("R8 postexec flag", {31'd0, lastPost}, 32'd1);
    chk("R8 no transfer", {31'd0, lastXfer}, 32'd0);
    wr(7'h17, 32'h0020_0000);
    rd(7'h16, r);             chk("R8 empty command idle", r, 32'h0200_0801);
    chk("R8 empty command no start", starts, s0 + 1);

    // R10 write while busy
    hartLat = 20;
    wr(7'h04, 32'h1111_2222);
    wr(7'h17, 32'h0023_1003);
    wr(7'h04, 32'h9999_9999);
    waitIdle(acs);            chk("R10 busy error", acs, 32'h0200_0901);
    rd(7'h04, r);             chk("R10 data0 write ignored", r, 32'h1111_2222);
    wr(7'h16, 32'h0000_0700);
    hartLat = 3;

    // Random commands
    modelData0 = 32'h1111_2222;
    for (int it = 0; it < 40; it++) begin
      logic [31:0] dd;
      logic [2:0]  sz;
      dd = $urandom;
      wr(7'h04, dd); modelData0 = dd;
      d = '0;
      if ($urandom % 8 == 0) d[31:24] = 8'($urandom);
      sz = ($urandom % 3 == 0) ? 3'($urandom) : 3'd2;
      d[22:20] = sz;
      d[19] = ($urandom % 8 == 0);
      d[18] = 1'($urandom);
      d[17] = ($urandom % 4 != 0);
      d[16] = 1'($urandom);
      d[15:0] = ($urandom % 4 == 0) ? 16'($urandom) : (16'h1000 | 16'($urandom % 32));
      wr(7'h17, d);
      waitIdle(acs);
      if (!supportedFn(d)) chk("R6 random reject", acs, 32'h0200_0A01);
      else                 chk("R7 random accept", acs, 32'h0200_0801);
      if (supportedFn(d) && d[17] && !d[16]) modelData0 = resultFn(d[15:0]);
      rd(7'h04, r);        chk("R7 random data0", r, modelData0);
      wr(7'h16, 32'h0000_0700);
    end

    // R2 deactivation
    wr(7'h10, 32'h8000_0001);
    wr(7'h10, 32'h0);
    chk("R2 haltReq cleared by deactivate", {31'd0, haltReq}, 32'd0);
    rd(7'h16, r);             chk("R2 abstractcs inactive", r, 32'd0);
    wr(7'h10, 32'h1);
    rd(7'h04, r);             chk("R2 data0 cleared", r, 32'd0);
    rd(7'h20, r);             chk("R2 progbuf cleared", r, 32'd0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule